// File: doc/BRIEF.md
# Interrupt Response Sequencer

This unit decides when an 8-bit CPU core answers an interrupt, and it carries out the answer as a short series of bus steps. Two kinds of request reach it. The first is a non-maskable pulse. The second is a maskable pulse that comes with a data byte. Each is held in a small latch until it is serviced. While the sequencer is idle it looks at the latches, at the core's enable flags and at the current response mode. When a request can be taken, it tells the core how to update its enable flags and its halt state, all in that same cycle.

Once a request is taken, the sequencer saves the return address on the stack as two byte writes. In the table-indirect mode it then reads a two-byte target from a table whose address is built from the core's page register and the data byte. In the other modes the target comes from fixed rules. Last, it hands the new program counter and stack pointer back to the core in a single-cycle load strobe. Every memory step holds its request until the memory answers ready.

Top module: `irq_vector_seq`

## Requirements
- R1: A pending non-maskable request is taken whatever the value of `iff1_i`. When both kinds are pending, the non-maskable one is serviced first and the maskable one stays latched.
- R2: A maskable request is taken only while `iff1_i` is 1. While `iff1_i` is 0 it stays latched (`irq_pending` = 1), `busy` stays 0 and there is no bus activity.
- R3: After a request is taken, the first two bus operations are writes. The first writes `ret[15:8]` at address SP-1 and the second writes `ret[7:0]` at address SP-2, where ret is the return PC and arithmetic wraps at 16 bits. Both writes come before any read and before `pc_load`, and `sp_new` equals SP-2.
- R4: If `halt_i` is 1 when a request is taken, the return PC is `pc_i`+1 (16-bit wrap) and `halt_clr` pulses in the acceptance cycle. Otherwise the return PC is `pc_i` and `halt_clr` stays 0.
- R5: A non-maskable acceptance pulses `iff_wr` with `iff1_nxt`=0, `iff2_nxt` equal to `iff2_i` and `ei_cancel`=0, and it loads PC 0x0066.
- R6: A maskable acceptance pulses `iff_wr` with `iff1_nxt`=0, `iff2_nxt`=0 and `ei_cancel`=1.
- R7: When `im_mode[1]` is 1, the table-indirect mode applies. The low target byte is read at {`ireg`, code} and the high byte at that address plus 1 (16-bit wrap), so `pc_new` = {high, low}.
- R8: When `im_mode` is 2'b01, the maskable target is 0x0038 whatever the data byte.
- R9: When `im_mode` is 2'b00, the data byte is a restart code and the target is code[5:3] times 8, which gives one of 0x0000 to 0x0038.
- R10: A maskable request pulse latches its data byte. With `AUTO_CLEAR`=1 the latch is cleared when that request is taken, unless a new request arrives in the same cycle, and `irq_pending` then reads 0.
- R11: While `mem_req` is 1 and `mem_ready` is 0, the request, address, data and direction hold steady, and the sequence advances only on `mem_ready`.
- R12: `busy` rises in the cycle after acceptance and stays high through the cycle in which `pc_load` pulses for one cycle. It is 0 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_req | input | 1 | Maskable request pulse |
| irq_data | input | 8 | Data byte supplied with the maskable request |
| im_mode | input | 2 | Response mode: 00 restart, 01 fixed, 1x table |
| iff1_i | input | 1 | Core maskable-enable flag |
| iff2_i | input | 1 | Core saved-enable flag |
| halt_i | input | 1 | Core is halted |
| ireg | input | 8 | Page register for table lookup |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| mem_ready | input | 1 | Memory completes the current access |
| mem_rdata | input | 8 | Read data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| iff_wr | output | 1 | Strobe: core loads the next flag values |
| iff1_nxt | output | 1 | Next maskable-enable flag |
| iff2_nxt | output | 1 | Next saved-enable flag |
| ei_cancel | output | 1 | Cancel a pending post-enable delay |
| halt_clr | output | 1 | Clear the core halt state |
| busy | output | 1 | Response sequence in progress |
| pc_load | output | 1 | Strobe: core loads `pc_new` and `sp_new` |
| pc_new | output | 16 | New program counter |
| sp_new | output | 16 | New stack pointer |
| irq_pending | output | 1 | A maskable request is latched |

## Verification
The bench builds the block with its default parameters, so `AUTO_CLEAR` is 1 and the fixed targets are 0x0066 and 0x0038. With auto-clear on, the maskable latch empties after each service, and the bench can read `irq_pending` to tell a consumed request from a held one. The memory model adds zero to three wait cycles to each access, which stretches the handshake holds. The stack and table cases wrap around 0xFFFF, and mode 2'b11 takes the table path.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PUSH_HI = 3'd1,
    ST_PUSH_LO = 3'd2,
    ST_VEC_LO  = 3'd3,
    ST_VEC_HI  = 3'd4,
    ST_LOAD    = 3'd5
  } seq_state_t;

  // Return address, stepping past a halt when the core is halted.
  function automatic logic [15:0] resume_pc(input logic [15:0] pc, input logic halted);
    return pc + {15'd0, halted};
  endfunction

  // Restart code bits [5:3] pick one of eight slots spaced 8 bytes apart.
  function automatic logic [15:0] restart_target(input logic [7:0] code);
    return {10'd0, code[5:3], 3'd0};
  endfunction

  // Table entry address: page register high, data byte low.
  function automatic logic [15:0] table_addr(input logic [7:0] page, input logic [7:0] code);
    return {page, code};
  endfunction

endpackage

// File: rtl/irqseq_req_latch.sv
module irqseq_req_latch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic [CODE_W-1:0] set_code,
  input  logic              clr,
  output logic              pend,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      code <= '0;
    end else if (set) begin
      pend <= 1'b1;
      code <= set_code;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end

  // R10: a new request always survives a same-cycle clear
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend);

endmodule

// File: rtl/irqseq_target.sv
module irqseq_target #(
  parameter logic [15:0] NMI_ADDR = 16'h0066,
  parameter logic [15:0] FIX_ADDR = 16'h0038
) (
  input  logic        is_nmi,
  input  logic [1:0]  mode,
  input  logic [7:0]  code,
  output logic [15:0] target,
  output logic        need_table
);
  import irqseq_pkg::*;

  always_comb begin
    need_table = 1'b0;
    if (is_nmi) begin
      target = NMI_ADDR;
    end else if (mode[1]) begin
      target     = 16'h0000;
      need_table = 1'b1;
    end else if (mode[0]) begin
      target = FIX_ADDR;
    end else begin
      target = restart_target(code);
    end
  end

endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq #(
  parameter logic [15:0] NMI_ADDR   = 16'h0066,
  parameter logic [15:0] FIX_ADDR   = 16'h0038,
  parameter bit          AUTO_CLEAR = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_req,
  input  logic        irq_req,
  input  logic [7:0]  irq_data,
  input  logic [1:0]  im_mode,
  input  logic        iff1_i,
  input  logic        iff2_i,
  input  logic        halt_i,
  input  logic [7:0]  ireg,
  input  logic [15:0] pc_i,
  input  logic [15:0] sp_i,
  input  logic        mem_ready,
  input  logic [7:0]  mem_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        iff_wr,
  output logic        iff1_nxt,
  output logic        iff2_nxt,
  output logic        ei_cancel,
  output logic        halt_clr,
  output logic        busy,
  output logic        pc_load,
  output logic [15:0] pc_new,
  output logic [15:0] sp_new,
  output logic        irq_pending
);
  import irqseq_pkg::*;

  seq_state_t  state;
  logic        nmi_pend;
  logic        nmi_unused;
  logic [7:0]  irq_code;
  logic        take_nmi, take_irq, accept;
  logic [15:0] tgt_c;
  logic        tbl_c;
  logic        nmi_s, tbl_s;
  logic [1:0]  mode_s;
  logic [15:0] tgt_s, ret_s, sp_s, vaddr_s;

  // request latches
  irqseq_req_latch #(.CODE_W(1)) u_nmi_latch (
    .clk(clk), .rst_n(rst_n), .set(nmi_req), .set_code(1'b1),
    .clr(take_nmi), .pend(nmi_pend), .code(nmi_unused)
  );

  irqseq_req_latch #(.CODE_W(8)) u_irq_latch (
    .clk(clk), .rst_n(rst_n), .set(irq_req), .set_code(irq_data),
    .clr(take_irq && AUTO_CLEAR), .pend(irq_pending), .code(irq_code)
  );

  // acceptance decision: non-maskable first, maskable gated by iff1
  assign take_nmi = (state == ST_IDLE) && nmi_pend;
  assign take_irq = (state == ST_IDLE) && !nmi_pend && irq_pending && iff1_i;
  assign accept   = take_nmi || take_irq;

  irqseq_target #(.NMI_ADDR(NMI_ADDR), .FIX_ADDR(FIX_ADDR)) u_target (
    .is_nmi(nmi_pend), .mode(im_mode), .code(irq_code),
    .target(tgt_c), .need_table(tbl_c)
  );

  // flag updates handed back to the core in the acceptance cycle
  assign iff_wr    = accept;
  assign iff1_nxt  = 1'b0;
  assign iff2_nxt  = take_nmi ? iff2_i : 1'b0;
  assign ei_cancel = take_irq;
  assign halt_clr  = accept && halt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      nmi_s   <= 1'b0;
      tbl_s   <= 1'b0;
      mode_s  <= 2'b00;
      tgt_s   <= 16'h0000;
      ret_s   <= 16'h0000;
      sp_s    <= 16'h0000;
      vaddr_s <= 16'h0000;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          nmi_s   <= take_nmi;
          tbl_s   <= tbl_c;
          mode_s  <= im_mode;
          tgt_s   <= tgt_c;
          ret_s   <= resume_pc(pc_i, halt_i);
          sp_s    <= sp_i;
          vaddr_s <= table_addr(ireg, irq_code);
          state   <= ST_PUSH_HI;
        end
        ST_PUSH_HI: if (mem_ready) state <= ST_PUSH_LO;
        ST_PUSH_LO: if (mem_ready) state <= tbl_s ? ST_VEC_LO : ST_LOAD;
        ST_VEC_LO: if (mem_ready) begin
          tgt_s[7:0] <= mem_rdata;
          state      <= ST_VEC_HI;
        end
        ST_VEC_HI: if (mem_ready) begin
          tgt_s[15:8] <= mem_rdata;
          state       <= ST_LOAD;
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // bus drive per step
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = 16'h0000;
    mem_wdata = 8'h00;
    unique case (state)
      ST_PUSH_HI: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = sp_s - 16'd1; mem_wdata = ret_s[15:8];
      end
      ST_PUSH_LO: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = sp_s - 16'd2; mem_wdata = ret_s[7:0];
      end
      ST_VEC_LO: begin
        mem_req = 1'b1; mem_addr = vaddr_s;
      end
      ST_VEC_HI: begin
        mem_req = 1'b1; mem_addr = vaddr_s + 16'd1;
      end
      default: ;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign pc_load = (state == ST_LOAD);
  assign pc_new  = tgt_s;
  assign sp_new  = sp_s - 16'd2;

  // R2: no maskable entry while disabled and no non-maskable pending
  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !nmi_pend && !iff1_i) |=> !busy);

  // R3: the first bus operation of a sequence is a write
  assert_push_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_req && mem_we));

  // R5: non-maskable service lands on its fixed address
  assert_nmi_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && nmi_s) |-> (pc_new == NMI_ADDR));

  // R8: fixed mode ignores the data byte
  assert_fixed_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !nmi_s && mode_s == 2'b01) |-> (pc_new == FIX_ADDR));

  // R11: a stalled access keeps its address and direction
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R12: busy drops right after the load strobe and not before
  assert_busy_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pc_load) |=> busy);

endmodule

// File: tb/irq_vector_seq_bench.sv
module irq_vector_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0, irq_req = 1'b0;
  logic [7:0]  irq_data = 8'h00;
  logic [1:0]  im_mode = 2'b00;
  logic        iff1_i = 1'b0, iff2_i = 1'b0, halt_i = 1'b0;
  logic [7:0]  ireg = 8'h00;
  logic [15:0] pc_i = 16'h0000, sp_i = 16'h0000;
  logic        mem_ready;
  logic [7:0]  mem_rdata;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        iff_wr, iff1_nxt, iff2_nxt, ei_cancel, halt_clr;
  logic        busy, pc_load;
  logic [15:0] pc_new, sp_new;
  logic        irq_pending;

  int checks = 0;
  int errors = 0;
  int wait_cfg = 0;

  always #4 clk = ~clk;

  irq_vector_seq u_irq_vector_seq (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
    .irq_data(irq_data), .im_mode(im_mode), .iff1_i(iff1_i), .iff2_i(iff2_i),
    .halt_i(halt_i), .ireg(ireg), .pc_i(pc_i), .sp_i(sp_i),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .iff_wr(iff_wr), .iff1_nxt(iff1_nxt), .iff2_nxt(iff2_nxt),
    .ei_cancel(ei_cancel), .halt_clr(halt_clr), .busy(busy),
    .pc_load(pc_load), .pc_new(pc_new), .sp_new(sp_new),
    .irq_pending(irq_pending)
  );

  // memory model: byte at address a reads as a[7:0] ^ 0x5A
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  int wcnt = 0;
  assign mem_ready = mem_req && (wcnt >= wait_cfg);
  assign mem_rdata = mem_byte(mem_addr);

  // monitor: write log, flag strobes, stall stability
  logic [15:0] wa [0:3];
  logic [7:0]  wd [0:3];
  int          nwr = 0;
  logic        l_iff1 = 1'b1, l_iff2 = 1'b0, l_ei = 1'b0, l_hclr = 1'b0;
  int          nstrobe = 0;
  logic        p_stall = 1'b0;
  logic [15:0] p_addr = 16'h0000;
  logic        p_we = 1'b0;
  int          stab_err = 0;

  always @(posedge clk) begin
    if (!mem_req || mem_ready) wcnt <= 0; else wcnt <= wcnt + 1;
    if (mem_req && mem_ready && mem_we) begin
      wa[nwr % 4] <= mem_addr;
      wd[nwr % 4] <= mem_wdata;
      nwr <= nwr + 1;
    end
    if (iff_wr) begin
      l_iff1 <= iff1_nxt; l_iff2 <= iff2_nxt; l_ei <= ei_cancel; l_hclr <= halt_clr;
      nstrobe <= nstrobe + 1;
    end
    if (p_stall && (!mem_req || mem_addr != p_addr || mem_we != p_we))
      stab_err <= stab_err + 1;
    p_stall <= mem_req && !mem_ready;
    p_addr  <= mem_addr;
    p_we    <= mem_we;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_load(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 64 && !seen; i++) begin
      @(negedge clk);
      if (pc_load) seen = 1'b1;
    end
  endtask

  typedef struct packed {
    logic        nmi;
    logic        irq;
    logic [1:0]  mode;
    logic        f1;
    logic        f2;
    logic        hlt;
    logic [1:0]  wt;
    logic [7:0]  code;
    logic [7:0]  page;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [15:0] exp_pc;
    logic        acc;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 16'h1000, 16'h8000, 16'h0066, 1'b1},
    '{1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1, 8'hFF, 8'h00, 16'h2345, 16'h9000, 16'h0038, 1'b1},
    '{1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 8'hEF, 8'h00, 16'h0100, 16'h4000, 16'h0028, 1'b1},
    '{1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 2'd2, 8'hC7, 8'h00, 16'h0ABC, 16'h4002, 16'h0000, 1'b1},
    '{1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 2'd1, 8'h34, 8'h12, 16'h0500, 16'hC000, 16'h6F6E, 1'b1},
    '{1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 2'd3, 8'hFF, 8'h20, 16'h7777, 16'h1234, 16'h5AA5, 1'b1},
    '{1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 8'h10, 8'h00, 16'h3000, 16'h5000, 16'h0038, 1'b0},
    '{1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 2'd2, 8'h00, 8'h00, 16'hFFFF, 16'h0001, 16'h0066, 1'b1},
    '{1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 2'd0, 8'hFF, 8'hFF, 16'h0042, 16'h2000, 16'h5AA5, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    int base;
    int sbase;
    logic [15:0] ret;
    repeat (3) @(negedge clk);
    // reset state (R12, R10)
    chk(!busy && !pc_load && !mem_req, "R12 reset idle", {busy, pc_load, mem_req}, 0);
    chk(!irq_pending, "R10 reset no pending", irq_pending, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vec_t t = TBL[v];
      im_mode = t.mode; iff1_i = t.f1; iff2_i = t.f2; halt_i = t.hlt;
      ireg = t.page; pc_i = t.pc; sp_i = t.sp; wait_cfg = int'(t.wt);
      irq_data = t.code; nmi_req = t.nmi; irq_req = t.irq;
      base = nwr; sbase = nstrobe;
      @(negedge clk);
      nmi_req = 1'b0; irq_req = 1'b0;
      if (!t.acc) begin
        // R2: blocked while iff1 is 0
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          chk(!busy && !mem_req, "R2 blocked no activity", busy, 0);
        end
        chk(irq_pending, "R2 request held", irq_pending, 1);
        iff1_i = 1'b1;
      end
      wait_load(seen);
      chk(seen, "R12 load strobe seen", seen, 1);
      chk(pc_new == t.exp_pc, "R5/R7/R8/R9 target pc", pc_new, t.exp_pc);
      chk(sp_new == t.sp - 16'd2, "R3 sp_new", sp_new, t.sp - 16'd2);
      chk(busy, "R12 busy during load", busy, 1);
      ret = t.pc + {15'd0, t.hlt};
      chk(nwr == base + 2, "R3 two writes", nwr - base, 2);
      chk(wa[base % 4] == t.sp - 16'd1 && wd[base % 4] == ret[15:8],
          "R3 R4 high byte push", {wa[base % 4], wd[base % 4]}, {t.sp - 16'd1, ret[15:8]});
      chk(wa[(base + 1) % 4] == t.sp - 16'd2 && wd[(base + 1) % 4] == ret[7:0],
          "R3 R4 low byte push", {wa[(base + 1) % 4], wd[(base + 1) % 4]}, {t.sp - 16'd2, ret[7:0]});
      chk(nstrobe == sbase + 1, "R6 single flag strobe", nstrobe - sbase, 1);
      chk(l_iff1 == 1'b0, "R5/R6 iff1 cleared", l_iff1, 0);
      chk(l_iff2 == (t.nmi ? t.f2 : 1'b0), "R5/R6 iff2 next", l_iff2, t.nmi ? t.f2 : 1'b0);
      chk(l_ei == !t.nmi, "R6 ei cancel", l_ei, !t.nmi);
      chk(l_hclr == t.hlt, "R4 halt clear", l_hclr, t.hlt);
      iff1_i = 1'b0;
      @(negedge clk);
      chk(!busy && !pc_load, "R12 idle after load", {busy, pc_load}, 0);
      chk(!irq_pending, "R10 auto cleared", irq_pending, 0);
    end

    // R1: both kinds at once, non-maskable first, maskable stays latched
    im_mode = 2'b01; iff1_i = 1'b1; iff2_i = 1'b1; halt_i = 1'b0;
    pc_i = 16'h4444; sp_i = 16'h6000; wait_cfg = 1; irq_data = 8'hD7;
    nmi_req = 1'b1; irq_req = 1'b1;
    @(negedge clk);
    nmi_req = 1'b0; irq_req = 1'b0;
    wait_load(seen);
    chk(seen && pc_new == 16'h0066, "R1 non-maskable first", pc_new, 16'h0066);
    chk(irq_pending, "R1 maskable still latched", irq_pending, 1);
    chk(l_iff2 == 1'b1, "R5 iff2 kept", l_iff2, 1);
    wait_load(seen);
    chk(seen && pc_new == 16'h0038, "R1 maskable serviced next", pc_new, 16'h0038);
    iff1_i = 1'b0;
    @(negedge clk);
    chk(!irq_pending, "R10 cleared after second service", irq_pending, 0);

    chk(stab_err == 0, "R11 stall stability", stab_err, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule